// File: doc/BRIEF.md
# UART Host Register Bank

This block is the software-facing side of a 16550-compatible serial port. A host reaches eight byte-wide registers through a 3-bit address with single-cycle read and write strobes. Read data is combinational. Side effects of a read, such as popping the receive queue or clearing sticky flags, take place on the clock edge that ends the read cycle. Bit 7 of the line control register overlays addresses 0 and 1: while it is set, they reach the two bytes of the baud divisor instead of the data port and the interrupt enable register.

Two small queues sit inside the bank. Host writes feed the transmit queue, which hands bytes to the transmit shift engine through a valid/ready pair. The receive shift engine pushes bytes, each with a framing-error flag, into the receive queue. An arbiter ranks four interrupt sources and drives one interrupt line. It also produces the identification code that software reads. A three-state machine tracks the transmit-empty interrupt. In TH_QUIET the queue is empty and nothing is pending. In TH_BUSY the queue holds data. In TH_PEND the queue has drained and the interrupt is pending. Any state moves to TH_BUSY when the queue is not empty. TH_BUSY moves to TH_PEND when the queue empties. TH_QUIET moves to TH_PEND when the enable bit is written from 0 to 1. TH_PEND moves to TH_QUIET when an identification read reports this source. Bit 4 of the modem control register selects internal loopback.

Top module: `uart_regbank`

## Requirements
- R1: While line-control bit 7 is 1, a write to address 0 sets divisor bits 7:0 and a write to address 1 sets divisor bits 15:8. Neither write enqueues a transmit byte, and reads of those addresses return the divisor bytes.
- R2: While line-control bit 7 is 0, a write to address 0 enqueues a byte for transmission, and address 1 reads and writes the interrupt enable register in bits 3:0. The enable bits are: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R3: A read of address 2 returns only the highest-priority enabled pending source. The codes are 0x06 for a line error (overrun or framing), 0x04 for received data, 0x02 for transmit empty and 0x00 for modem status. The value 0x01 means nothing is pending.
- R4: When the transmit-empty interrupt is enabled, it becomes pending when the transmit queue drains to empty. It also becomes pending when enable bit 1 is written from 0 to 1 while the queue is empty.
- R5: A read of address 2 that reports 0x02 clears the transmit-empty pending state. The next identification read then shows the next source, or 0x01.
- R6: A write to address 2 with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. These bits act only in the cycle of that write: a later write without them leaves the queue contents intact.
- R7: A write to address 0 while the transmit queue holds FIFO_DEPTH bytes is discarded. The accepted bytes leave in order.
- R8: When modem-control bit 4 is 1, sout_pin is 1 and rx_line equals tx_line. When it is 0, sout_pin equals tx_line and rx_line equals sin_pin.
- R9: Address 5 reads line status. The bits are: bit 0 receive data ready, bit 1 overrun, bit 3 framing error, bit 5 transmit queue empty, bit 6 transmitter empty (queue empty and tx_idle high). Bits 1 and 3 clear when this register is read.
- R10: Address 6 reads modem status. Bit 4 is the current clear-to-send level, which follows modem-control bit 1 in loopback. Bit 0 is set when that level changes and clears when this register is read.
- R11: A read of address 0 returns the oldest received byte and removes it. A byte that arrives while the receive queue is full is dropped and sets the overrun bit.
- R12: irq is high exactly when the identification code is not 0x01.
- R13: After reset the identification register reads 0x01 and line status reads 0x60. The divisor is 0, irq is 0 and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| divisor | output | 16 | Baud divisor |
| line_cfg | output | 7 | Line control bits 6:0 for the shift engines |
| tx_valid | output | 1 | Transmit queue has a byte |
| tx_data | output | 8 | Head of transmit queue |
| tx_ready | input | 1 | Transmit engine takes the head byte |
| tx_idle | input | 1 | Transmit shifter is idle |
| rx_valid | input | 1 | Receive engine pushes a byte |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Received byte had a bad stop bit |
| cts_in | input | 1 | Clear-to-send level |
| tx_line | input | 1 | Serial output of the transmit shifter |
| sin_pin | input | 1 | External serial input |
| sout_pin | output | 1 | External serial output |
| rx_line | output | 1 | Serial input to the receive shifter |

## Verification
The bench fills the transmit queue past its depth. A design that accepted the extra writes, or overwrote the head, would deliver a byte sequence different from the bench model. It raises all four interrupt sources at once and clears them one at a time. A wrong ranking or an identification read that cleared the wrong source shows up as a wrong code at some step. It also checks that divisor writes under the overlay bit never reach the transmit queue, and that a plain FIFO control write after a reset write keeps queued data, which would be lost if the reset bits were sticky. Loopback is checked for a high output pin and for the transmit line turning back to the receiver.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_IEN   = 3'd1;
    localparam logic [2:0] A_IDENT = 3'd2;
    localparam logic [2:0] A_LCTL  = 3'd3;
    localparam logic [2:0] A_MCTL  = 3'd4;
    localparam logic [2:0] A_LSTAT = 3'd5;
    localparam logic [2:0] A_MSTAT = 3'd6;
    localparam logic [2:0] A_SCR   = 3'd7;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXDATA,
        SRC_TXEMPTY,
        SRC_MODEM
    } irq_src_e;

    typedef enum logic [1:0] {
        TH_QUIET,
        TH_BUSY,
        TH_PEND
    } th_state_e;

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_thre_tracker.sv
module uart_thre_tracker
    import uart_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic arm,
    input  logic ack,
    output logic pending
);
    th_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_QUIET: begin
                if (!tx_empty) state_d = TH_BUSY;
                else if (arm)  state_d = TH_PEND;
            end
            TH_BUSY: begin
                if (tx_empty) state_d = TH_PEND;
            end
            TH_PEND: begin
                if (!tx_empty) state_d = TH_BUSY;
                else if (ack)  state_d = TH_QUIET;
            end
            default: state_d = TH_QUIET;
        endcase
    end

    assign pending = (state_q == TH_PEND);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_regbank_pkg::*;
(
    input  logic [3:0] ien,
    input  logic       line_err,
    input  logic       rx_avail,
    input  logic       thre_pend,
    input  logic       modem_chg,
    output irq_src_e   src,
    output logic [7:0] ident,
    output logic       irq
);
    always_comb begin
        if (ien[2] && line_err)       src = SRC_LINE;
        else if (ien[0] && rx_avail)  src = SRC_RXDATA;
        else if (ien[1] && thre_pend) src = SRC_TXEMPTY;
        else if (ien[3] && modem_chg) src = SRC_MODEM;
        else                          src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_LINE:    ident = 8'h06;
            SRC_RXDATA:  ident = 8'h04;
            SRC_TXEMPTY: ident = 8'h02;
            SRC_MODEM:   ident = 8'h00;
            default:     ident = 8'h01;
        endcase
    end

    assign irq = (src != SRC_NONE);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic [15:0] divisor,
    output logic [6:0]  line_cfg,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        tx_idle,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_ferr,
    input  logic        cts_in,
    input  logic        tx_line,
    input  logic        sin_pin,
    output logic        sout_pin,
    output logic        rx_line
);
    logic [7:0] lcr_q, dll_q, dlm_q, scr_q;
    logic [3:0] ier_q;
    logic [4:0] mcr_q;
    logic       oe_q, fe_q, cts_q, dcts_q;

    logic       dlab, loop_en, cts_eff;
    logic       tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0] rx_head;
    logic       tx_push, rx_pop, tx_flush, rx_flush;
    logic       lsr_rd, msr_rd, ident_rd, thre_arm;
    logic       thre_pend;
    irq_src_e   src;
    logic [7:0] ident;
    logic [7:0] lsr, msr;

    assign dlab     = lcr_q[7];
    assign loop_en  = mcr_q[4];
    assign cts_eff  = loop_en ? mcr_q[1] : cts_in;

    assign tx_push  = bus_wr && (bus_addr == A_DATA) && !dlab;
    assign rx_pop   = bus_rd && (bus_addr == A_DATA) && !dlab;
    assign tx_flush = bus_wr && (bus_addr == A_IDENT) && bus_wdata[2];
    assign rx_flush = bus_wr && (bus_addr == A_IDENT) && bus_wdata[1];
    assign lsr_rd   = bus_rd && (bus_addr == A_LSTAT);
    assign msr_rd   = bus_rd && (bus_addr == A_MSTAT);
    assign ident_rd = bus_rd && (bus_addr == A_IDENT);
    assign thre_arm = bus_wr && (bus_addr == A_IEN) && !dlab
                      && bus_wdata[1] && !ier_q[1];

    uart_sync_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .push_data(bus_wdata),
        .pop(tx_ready), .head(tx_data),
        .empty(tx_empty), .full(tx_full)
    );

    uart_sync_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_valid), .push_data(rx_data),
        .pop(rx_pop), .head(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    uart_thre_tracker u_thre (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty),
        .arm(thre_arm), .ack(ident_rd && (src == SRC_TXEMPTY)),
        .pending(thre_pend)
    );

    uart_irq_arbiter u_arb (
        .ien(ier_q), .line_err(oe_q || fe_q), .rx_avail(!rx_empty),
        .thre_pend(thre_pend), .modem_chg(dcts_q),
        .src(src), .ident(ident), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= '0;
            dll_q <= '0;
            dlm_q <= '0;
            scr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_DATA:  if (dlab) dll_q <= bus_wdata;
                A_IEN:   if (dlab) dlm_q <= bus_wdata;
                         else      ier_q <= bus_wdata[3:0];
                A_LCTL:  lcr_q <= bus_wdata;
                A_MCTL:  mcr_q <= bus_wdata[4:0];
                A_SCR:   scr_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            fe_q   <= 1'b0;
            cts_q  <= 1'b0;
            dcts_q <= 1'b0;
        end else begin
            if (rx_valid && rx_full)                oe_q <= 1'b1;
            else if (lsr_rd)                        oe_q <= 1'b0;
            if (rx_valid && !rx_full && rx_ferr)    fe_q <= 1'b1;
            else if (lsr_rd)                        fe_q <= 1'b0;
            cts_q <= cts_eff;
            if (cts_eff != cts_q)                   dcts_q <= 1'b1;
            else if (msr_rd)                        dcts_q <= 1'b0;
        end
    end

    assign lsr = {1'b0, tx_empty && tx_idle, tx_empty, 1'b0,
                  fe_q, 1'b0, oe_q, !rx_empty};
    assign msr = {3'b000, cts_q, 3'b000, dcts_q};

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = dlab ? dll_q : rx_head;
            A_IEN:   bus_rdata = dlab ? dlm_q : {4'b0000, ier_q};
            A_IDENT: bus_rdata = ident;
            A_LCTL:  bus_rdata = lcr_q;
            A_MCTL:  bus_rdata = {3'b000, mcr_q};
            A_LSTAT: bus_rdata = lsr;
            A_MSTAT: bus_rdata = msr;
            default: bus_rdata = scr_q;
        endcase
    end

    assign tx_valid = !tx_empty;
    assign divisor  = {dlm_q, dll_q};
    assign line_cfg = lcr_q[6:0];
    assign sout_pin = loop_en ? 1'b1 : tx_line;
    assign rx_line  = loop_en ? tx_line : sin_pin;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic       sout_pin,
    input logic       tx_valid,
    input logic       dlab
);
    // R1: divisor writes never reach the transmit queue
    a_r1_dlab_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && dlab && !tx_valid) |=> !tx_valid);

    // R2: data writes with the overlay bit clear enqueue
    a_r2_data_write_enqueues: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !dlab) |=> tx_valid);

    // R6: transmit reset empties the queue
    a_r6_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && bus_wdata[2]) |=> !tx_valid);

    // R8: loopback forces the output pin high
    a_r8_loop_sout_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4 && bus_wdata[4]) |=> sout_pin);

    // R9: transmitter empty implies queue empty
    a_r9_temt_needs_thre: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5) |-> (!bus_rdata[6] || bus_rdata[5]));

    // R12: interrupt line agrees with identification bit 0
    a_r12_irq_matches_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd2) |-> (bus_rdata[0] != irq));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sout_pin(sout_pin), .tx_valid(tx_valid), .dlab(lcr_q[7])
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic [15:0] divisor;
    logic [6:0]  line_cfg;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0, tx_idle = 1'b1;
    logic        rx_valid = 1'b0, rx_ferr = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        cts_in = 1'b0, tx_line = 1'b0, sin_pin = 1'b1;
    logic        sout_pin, rx_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] mdl [DEPTH];
    logic [7:0] d;

    always #2 clk = ~clk;

    uart_regbank #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .divisor(divisor), .line_cfg(line_cfg),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_idle(tx_idle), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .cts_in(cts_in), .tx_line(tx_line),
        .sin_pin(sin_pin), .sout_pin(sout_pin), .rx_line(rx_line)
    );

    function automatic logic [7:0] exp_lsr(input bit dr, input bit oe,
                                           input bit fe, input bit thre,
                                           input bit temt);
        return {1'b0, temt, thre, 1'b0, fe, 1'b0, oe, dr};
    endfunction

    function automatic logic [7:0] exp_msr(input bit cts, input bit dcts);
        return {3'b000, cts, 3'b000, dcts};
    endfunction

    task automatic expect_eq(input string req, input logic [15:0] act,
                             input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] v, input bit fe);
        @(negedge clk);
        rx_data = v; rx_ferr = fe; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] v);
        @(negedge clk);
        v = tx_data; tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        bus_read(3'd2, d); expect_eq("R13 ident", d, 8'h01);
        bus_read(3'd5, d); expect_eq("R13 lstat", d, exp_lsr(0,0,0,1,1));
        expect_eq("R13 divisor", divisor, 16'h0000);
        expect_eq("R13 irq", irq, 1'b0);
        tx_line = 1'b0; sin_pin = 1'b1; #1;
        expect_eq("R8 sout normal", sout_pin, 1'b0);
        expect_eq("R8 rx_line normal", rx_line, 1'b1);

        // R1: overlay on
        bus_write(3'd3, 8'h83);
        bus_write(3'd0, 8'h34);
        bus_write(3'd1, 8'h12);
        expect_eq("R1 divisor", divisor, 16'h1234);
        expect_eq("R1 no tx byte", tx_valid, 1'b0);
        bus_read(3'd1, d); expect_eq("R1 divisor high read", d, 8'h12);
        bus_read(3'd0, d); expect_eq("R1 divisor low read", d, 8'h34);

        // R2: overlay off
        bus_write(3'd3, 8'h03);
        expect_eq("R2 line_cfg", line_cfg, 7'h03);
        bus_read(3'd1, d); expect_eq("R2 ien read", d, 8'h00);
        bus_write(3'd0, 8'hA5);
        expect_eq("R2 tx_valid", tx_valid, 1'b1);
        expect_eq("R2 tx_data", tx_data, 8'hA5);
        expect_eq("R2 divisor kept", divisor, 16'h1234);

        // R4 / R5: transmit-empty interrupt
        bus_write(3'd1, 8'h02);
        bus_read(3'd2, d); expect_eq("R4 not yet pending", d, 8'h01);
        pop_tx(d);
        repeat (2) @(negedge clk);
        expect_eq("R12 irq on", irq, 1'b1);
        bus_read(3'd2, d); expect_eq("R4 thre code", d, 8'h02);
        bus_read(3'd2, d); expect_eq("R5 cleared by ident read", d, 8'h01);
        expect_eq("R12 irq off", irq, 1'b0);

        // R9: transmitter-empty needs idle shifter
        tx_idle = 1'b0; #1;
        bus_read(3'd5, d); expect_eq("R9 temt busy", d, exp_lsr(0,0,0,1,0));
        tx_idle = 1'b1;

        // R7: random fills past the depth
        for (int r = 0; r < 4; r++) begin
            int n, kept;
            n = $urandom_range(DEPTH + 4, 1);
            kept = (n > DEPTH) ? DEPTH : n;
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                if (i < DEPTH) mdl[i] = b;
                bus_write(3'd0, b);
            end
            for (int i = 0; i < kept; i++) begin
                pop_tx(d);
                expect_eq("R7 tx order", d, mdl[i]);
            end
            expect_eq("R7 tx drained", tx_valid, 1'b0);
        end
        repeat (2) @(negedge clk);
        bus_read(3'd2, d); expect_eq("R4 pending after drain", d, 8'h02);

        // R11: random receive fills with overrun
        for (int r = 0; r < 3; r++) begin
            int n, kept;
            n = $urandom_range(DEPTH + 3, 1);
            kept = (n > DEPTH) ? DEPTH : n;
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                if (i < DEPTH) mdl[i] = b;
                push_rx(b, 1'b0);
            end
            bus_read(3'd5, d);
            expect_eq("R11 lstat overrun", d, exp_lsr(1, n > DEPTH, 0, 1, 1));
            bus_read(3'd5, d);
            expect_eq("R9 overrun cleared", d, exp_lsr(1, 0, 0, 1, 1));
            for (int i = 0; i < kept; i++) begin
                bus_read(3'd0, d);
                expect_eq("R11 rx order", d, mdl[i]);
            end
            bus_read(3'd5, d); expect_eq("R11 rx empty", d, exp_lsr(0,0,0,1,1));
        end

        // R3: all sources at once, cleared in priority order
        bus_write(3'd1, 8'h0F);
        cts_in = 1'b1;
        bus_write(3'd0, 8'h55);
        pop_tx(d);
        push_rx(8'h77, 1'b1);
        repeat (2) @(negedge clk);
        bus_read(3'd2, d); expect_eq("R3 line first", d, 8'h06);
        bus_read(3'd5, d); expect_eq("R9 framing", d, exp_lsr(1,0,1,1,1));
        bus_read(3'd2, d); expect_eq("R3 rxdata second", d, 8'h04);
        bus_read(3'd0, d); expect_eq("R11 rx byte", d, 8'h77);
        bus_read(3'd2, d); expect_eq("R3 thre third", d, 8'h02);
        bus_read(3'd2, d); expect_eq("R3 modem last", d, 8'h00);
        bus_read(3'd6, d); expect_eq("R10 dcts", d, exp_msr(1, 1));
        bus_read(3'd2, d); expect_eq("R3 none", d, 8'h01);
        expect_eq("R12 irq idle", irq, 1'b0);

        // R6: queue resets and self-clearing
        bus_write(3'd1, 8'h00);
        push_rx(8'h11, 0); push_rx(8'h22, 0);
        bus_write(3'd0, 8'h01); bus_write(3'd0, 8'h02);
        bus_write(3'd2, 8'h06);
        expect_eq("R6 tx flushed", tx_valid, 1'b0);
        bus_read(3'd5, d); expect_eq("R6 rx flushed", d, exp_lsr(0,0,0,1,1));
        push_rx(8'h3C, 0);
        bus_write(3'd0, 8'h99);
        bus_write(3'd2, 8'h01);
        bus_read(3'd0, d); expect_eq("R6 rx kept", d, 8'h3C);
        expect_eq("R6 tx kept", tx_data, 8'h99);
        pop_tx(d);

        // R10 / R8: modem status and loopback
        cts_in = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(3'd6, d); expect_eq("R10 cts fall", d, exp_msr(0, 1));
        bus_read(3'd6, d); expect_eq("R10 dcts cleared", d, exp_msr(0, 0));
        bus_write(3'd4, 8'h10);
        tx_line = 1'b0; sin_pin = 1'b1; #1;
        expect_eq("R8 loop sout", sout_pin, 1'b1);
        expect_eq("R8 loop rx_line 0", rx_line, 1'b0);
        tx_line = 1'b1; sin_pin = 1'b0; #1;
        expect_eq("R8 loop rx_line 1", rx_line, 1'b1);
        bus_write(3'd4, 8'h12);
        repeat (2) @(negedge clk);
        bus_read(3'd6, d); expect_eq("R10 loop cts", d, exp_msr(1, 1));
        bus_write(3'd4, 8'h00);
        tx_line = 1'b0; #1;
        expect_eq("R8 loop off", sout_pin, 1'b0);

        finish_run();
    end
endmodule